// File: doc/BRIEF.md
# Sequencer Run-Control and Debug Unit

This unit decides, cycle by cycle, whether a small sequencing engine may issue instructions. It holds the engine's run state (running, stopped by software, stopped on a breakpoint or trap, halted, or fatally stopped) and moves between those states on retire events from the engine, on hardware error events, and on configuration writes from a controlling agent. It contains one address comparator for the breakpoint, a stall timer for timed waits, a retired-instruction counter, and a pair of error-capture registers that lock on the first error.

The engine reports every retiring instruction with its PC, a class (plain, TRAP or WAIT) and, for WAIT, a count. Software changes the run state through a single write port with a 3-bit select: control bits, breakpoint address, trap enable, PC override, error clear, base address and execute trigger. The unit answers with an issue enable, a one-cycle PC-load request with its target, a side-effect-free status word and single-cycle interrupt pulses. All control and status pins are plain level or pulse signals. No data stream crosses the block, so it has no valid/ready handshake.

A parameter selects how the unit leaves reset. With `AUTO_RUN=1` it leaves reset running from `RESET_VEC`. With `AUTO_RUN=0` it leaves reset stopped and starts only once a base address and then an execute trigger have been written.

Top module: `runctl_unit`

## Requirements
- R1: With AUTO_RUN=1, after reset the status is running (`status_o` = 6'b000001; bit 0 running, 1 software stop, 2 breakpoint/trap stop, 3 halted, 4 fatal, 5 error locked), `issue_en_o` is 1, `retire_cnt_o` is 0 and `pc_load_addr_o` equals `RESET_VEC`.
- R2: With AUTO_RUN=0, the unit leaves reset stopped (status 6'b000010). A start bit and an execute trigger (select 6) are both ignored until a base address (select 5) has been written. An execute trigger after that loads the base address through a one-cycle `pc_load_o` pulse and enters running.
- R3: A retire in the running state whose PC equals the breakpoint address (select 1) moves the unit to breakpoint stop in the next cycle. The retiring instruction is still counted, and `issue_en_o` drops.
- R4: The breakpoint has no disable bit. Its reset value is all ones, a reserved address, so retiring ordinary PCs never stops the engine.
- R5: Retire class 1 is TRAP. With trap enable (select 2, bit 0) clear, it acts as a plain instruction. With trap enable set, it enters breakpoint stop.
- R6: A control write (select 0) with bit 0 set stops the unit from any non-fatal state, including breakpoint stop. Bit 1 restarts a stopped unit. When both bits are set in one write, stop wins.
- R7: Retire class 2 (WAIT) with count 0 enters the halted state and raises `halt_irq_o` for exactly one cycle.
- R8: WAIT with a nonzero count n keeps `issue_en_o` low for exactly n cycles, starting the cycle after the retire, while the status stays running.
- R9: A PC override write (select 3) stops the unit, pulses `pc_load_o` for one cycle with `pc_load_addr_o` set to the written value, and the unit stays stopped afterwards.
- R10: The first hardware error captures its code and PC in the two capture registers, sets the lock (status bit 5) and pulses `err_irq_o` once. The run state is unchanged.
- R11: A hardware error while the lock is set enters the fatal state and pulses `fatal_o` once. The captured values are kept.
- R12: An error clear write (select 4) zeroes both capture registers and releases the lock. A start request while the lock is set is ignored.
- R13: `retire_cnt_o` rises by one on every retire strobe. A WAIT counts once, whatever its count.
- R14: Same-cycle priority, highest first: an error while locked, then a stop or PC override, then start or execute, then retire events. A stop written in the same cycle as a breakpoint retire leaves the unit in software stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retires this cycle |
| retire_pc_i | input | PC_W | PC of the retiring instruction |
| retire_cls_i | input | 2 | 0 plain, 1 TRAP, 2 WAIT |
| wait_cnt_i | input | WAIT_W | WAIT count (0 means halt) |
| hw_err_i | input | 1 | Hardware error event |
| hw_err_code_i | input | ERR_W | Error code to capture |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select 0..6 |
| cfg_wdata_i | input | PC_W | Write data |
| issue_en_o | output | 1 | Engine may issue |
| pc_load_o | output | 1 | One-cycle PC load request |
| pc_load_addr_o | output | PC_W | PC load target (last loaded value) |
| status_o | output | 6 | Run state and lock bits |
| retire_cnt_o | output | CNT_W | Retired instruction count |
| err_cap_code_o | output | ERR_W | First capture register: error code |
| err_cap_pc_o | output | PC_W | Second capture register: PC at error |
| err_irq_o | output | 1 | Recoverable error pulse |
| fatal_o | output | 1 | Fatal error pulse |
| halt_irq_o | output | 1 | Halt pulse from WAIT 0 |

## Verification
The case that matters most is two events that act on the run state in the same clock. One is a control write that stops the engine while the engine retires an instruction at the breakpoint address. The other is a second hardware error while locked arriving together with a stop write. The bench drives the write strobe and the retire or error strobe in one cycle. It then reads the status word one edge later and expects software stop in the first case and the fatal state in the second.

// File: rtl/runctl_pkg.sv
package runctl_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_STOP  = 3'd1,
    ST_BRK   = 3'd2,
    ST_HALT  = 3'd3,
    ST_FATAL = 3'd4
  } run_state_e;

  localparam logic [1:0] CLS_PLAIN = 2'd0;
  localparam logic [1:0] CLS_TRAP  = 2'd1;
  localparam logic [1:0] CLS_WAIT  = 2'd2;

  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_BP     = 3'd1;
  localparam logic [2:0] SEL_TRAPEN = 3'd2;
  localparam logic [2:0] SEL_PCSET  = 3'd3;
  localparam logic [2:0] SEL_ERRCLR = 3'd4;
  localparam logic [2:0] SEL_BASE   = 3'd5;
  localparam logic [2:0] SEL_EXEC   = 3'd6;

  localparam int STAT_W = 6;

endpackage

// File: rtl/runctl_bpcmp.sv
module runctl_bpcmp #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [PC_W-1:0] addr_i,
  input  logic            retire_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            hit_o
);
  localparam logic [PC_W-1:0] NEVER_PC = '1;

  logic [PC_W-1:0] bp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bp_q <= NEVER_PC;
    else if (wr_i) bp_q <= addr_i;
  end

  assign hit_o = retire_i && (pc_i == bp_q);
endmodule

// File: rtl/runctl_stall.sv
module runctl_stall #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] cnt_i,
  input  logic              flush_i,
  output logic              busy_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (flush_i)        cnt_q <= '0;
    else if (load_i)         cnt_q <= cnt_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_STALL_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !flush_i && !load_i |=> cnt_q == $past(cnt_q) - 1'b1); // R8
endmodule

// File: rtl/runctl_retcnt.sv
module runctl_retcnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_o <= '0;
    else if (retire_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |=> cnt_o == $past(cnt_o) + 1'b1); // R13
endmodule

// File: rtl/runctl_errcap.sv
module runctl_errcap #(
  parameter int PC_W  = 32,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_i,
  input  logic [ERR_W-1:0] code_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] cap_code_o,
  output logic [PC_W-1:0]  cap_pc_o,
  output logic             locked_o,
  output logic             fatal_hit_o,
  output logic             irq_o,
  output logic             fatal_o
);
  logic take;

  // A clear in the same cycle as an error re-arms and captures the new one.
  assign take        = err_i && (!locked_o || clr_i);
  assign fatal_hit_o = err_i && locked_o && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_code_o <= '0;
      cap_pc_o   <= '0;
      locked_o   <= 1'b0;
    end else if (take) begin
      cap_code_o <= code_i;
      cap_pc_o   <= pc_i;
      locked_o   <= 1'b1;
    end else if (clr_i) begin
      cap_code_o <= '0;
      cap_pc_o   <= '0;
      locked_o   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o   <= 1'b0;
      fatal_o <= 1'b0;
    end else begin
      irq_o   <= take;
      fatal_o <= fatal_hit_o;
    end
  end

  AST_FIRST_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_i && !locked_o |=> locked_o && irq_o); // R10
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o && !clr_i |=> $stable(cap_code_o) && $stable(cap_pc_o)); // R11
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !err_i |=> !locked_o && cap_code_o == '0); // R12
endmodule

// File: rtl/runctl_unit.sv
module runctl_unit
  import runctl_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter int              WAIT_W    = 16,
  parameter int              ERR_W     = 8,
  parameter int              CNT_W     = 64,
  parameter bit              AUTO_RUN  = 1'b1,
  parameter logic [PC_W-1:0] RESET_VEC = PC_W'(256)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                retire_i,
  input  logic [PC_W-1:0]     retire_pc_i,
  input  logic [1:0]          retire_cls_i,
  input  logic [WAIT_W-1:0]   wait_cnt_i,
  input  logic                hw_err_i,
  input  logic [ERR_W-1:0]    hw_err_code_i,
  input  logic                cfg_we_i,
  input  logic [2:0]          cfg_sel_i,
  input  logic [PC_W-1:0]     cfg_wdata_i,
  output logic                issue_en_o,
  output logic                pc_load_o,
  output logic [PC_W-1:0]     pc_load_addr_o,
  output logic [STAT_W-1:0]   status_o,
  output logic [CNT_W-1:0]    retire_cnt_o,
  output logic [ERR_W-1:0]    err_cap_code_o,
  output logic [PC_W-1:0]     err_cap_pc_o,
  output logic                err_irq_o,
  output logic                fatal_o,
  output logic                halt_irq_o
);
  localparam run_state_e RST_STATE = AUTO_RUN ? ST_RUN : ST_STOP;

  run_state_e      st_q, st_d;
  logic            trap_en_q, armed_q, base_vld_q;
  logic [PC_W-1:0] base_q;
  logic            bp_hit, stall_busy, locked, fatal_hit;
  logic            ld_d, halt_d, stall_load, stall_flush;
  logic [PC_W-1:0] ld_addr_d;

  // write decode
  logic stop_req, start_req, ovr_req, exec_req, clr_req, bp_wr;
  assign stop_req  = cfg_we_i && cfg_sel_i == SEL_CTRL && cfg_wdata_i[0];
  assign start_req = cfg_we_i && cfg_sel_i == SEL_CTRL && cfg_wdata_i[1] && armed_q;
  assign ovr_req   = cfg_we_i && cfg_sel_i == SEL_PCSET;
  assign exec_req  = cfg_we_i && cfg_sel_i == SEL_EXEC && base_vld_q;
  assign clr_req   = cfg_we_i && cfg_sel_i == SEL_ERRCLR;
  assign bp_wr     = cfg_we_i && cfg_sel_i == SEL_BP;

  logic is_halt, is_trap, is_wait;
  assign is_wait = retire_cls_i == CLS_WAIT;
  assign is_halt = is_wait && wait_cnt_i == '0;
  assign is_trap = retire_cls_i == CLS_TRAP && trap_en_q;

  runctl_bpcmp #(.PC_W(PC_W)) u_bp (
    .clk(clk), .rst_n(rst_n), .wr_i(bp_wr), .addr_i(cfg_wdata_i),
    .retire_i(retire_i), .pc_i(retire_pc_i), .hit_o(bp_hit)
  );

  runctl_stall #(.WAIT_W(WAIT_W)) u_stall (
    .clk(clk), .rst_n(rst_n), .load_i(stall_load), .cnt_i(wait_cnt_i),
    .flush_i(stall_flush), .busy_o(stall_busy)
  );

  runctl_retcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .cnt_o(retire_cnt_o)
  );

  runctl_errcap #(.PC_W(PC_W), .ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .err_i(hw_err_i), .code_i(hw_err_code_i),
    .pc_i(retire_pc_i), .clr_i(clr_req), .cap_code_o(err_cap_code_o),
    .cap_pc_o(err_cap_pc_o), .locked_o(locked), .fatal_hit_o(fatal_hit),
    .irq_o(err_irq_o), .fatal_o(fatal_o)
  );

  // next-state with fixed priority: fatal > stop/override > start/exec > retire
  always_comb begin
    st_d       = st_q;
    ld_d       = 1'b0;
    ld_addr_d  = pc_load_addr_o;
    halt_d     = 1'b0;
    stall_load = 1'b0;
    if (fatal_hit) begin
      st_d = ST_FATAL;
    end else if (stop_req || ovr_req) begin
      st_d = ST_STOP;
      if (ovr_req) begin
        ld_d      = 1'b1;
        ld_addr_d = cfg_wdata_i;
      end
    end else if (!locked && exec_req) begin
      st_d      = ST_RUN;
      ld_d      = 1'b1;
      ld_addr_d = base_q;
    end else if (!locked && start_req && st_q != ST_RUN) begin
      st_d = ST_RUN;
    end else if (st_q == ST_RUN && retire_i) begin
      if (is_halt) begin
        st_d   = ST_HALT;
        halt_d = 1'b1;
      end else if (is_trap || bp_hit) begin
        st_d = ST_BRK;
      end else if (is_wait) begin
        stall_load = 1'b1;
      end
    end
    stall_flush = (st_d != ST_RUN) || ld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= RST_STATE;
      pc_load_o      <= 1'b0;
      pc_load_addr_o <= RESET_VEC;
      halt_irq_o     <= 1'b0;
    end else begin
      st_q           <= st_d;
      pc_load_o      <= ld_d;
      pc_load_addr_o <= ld_addr_d;
      halt_irq_o     <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_en_q  <= 1'b0;
      base_q     <= '0;
      base_vld_q <= 1'b0;
      armed_q    <= AUTO_RUN;
    end else begin
      if (cfg_we_i && cfg_sel_i == SEL_TRAPEN) trap_en_q <= cfg_wdata_i[0];
      if (cfg_we_i && cfg_sel_i == SEL_BASE) begin
        base_q     <= cfg_wdata_i;
        base_vld_q <= 1'b1;
      end
      if (exec_req && !locked) armed_q <= 1'b1;
    end
  end

  assign issue_en_o = (st_q == ST_RUN) && !stall_busy;
  assign status_o   = {locked, st_q == ST_FATAL, st_q == ST_HALT,
                       st_q == ST_BRK, st_q == ST_STOP, st_q == ST_RUN};

  AST_BP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_RUN && bp_hit && !is_halt && !stop_req && !ovr_req &&
    !fatal_hit && !exec_req |=> status_o[2]); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req || ovr_req) && !fatal_hit |=> status_o[1]); // R14
  AST_LOCK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    locked && st_q != ST_RUN |=> !status_o[0]); // R12
  AST_FATAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_hit |=> status_o[4] && fatal_o); // R11
  AST_OVR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_req && !fatal_hit |=> pc_load_o && pc_load_addr_o == $past(cfg_wdata_i)); // R9
  AST_HALT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    halt_irq_o |-> status_o[3] && !issue_en_o); // R7
endmodule

// File: tb/tb_runctl_unit.sv
module tb_runctl_unit;
  localparam logic [5:0] S_RUN = 6'b000001, S_STOP = 6'b000010, S_BRK = 6'b000100,
                         S_HALT = 6'b001000, S_FATAL = 6'b010000, S_LOCK = 6'b100000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        retire = 1'b0, hw_err = 1'b0, cfg_we = 1'b0;
  logic [31:0] retire_pc = '0, cfg_wdata = '0;
  logic [1:0]  retire_cls = '0;
  logic [15:0] wait_cnt = '0;
  logic [7:0]  err_code = '0;
  logic [2:0]  cfg_sel = '0;

  logic        issue_a, pcl_a, irq_a, fat_a, hirq_a;
  logic [31:0] pcla_a, cpc_a;
  logic [5:0]  st_a;
  logic [63:0] cnt_a;
  logic [7:0]  ccode_a;
  logic        issue_b, pcl_b, irq_b, fat_b, hirq_b;
  logic [31:0] pcla_b, cpc_b;
  logic [5:0]  st_b;
  logic [63:0] cnt_b;
  logic [7:0]  ccode_b;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  runctl_unit dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .retire_pc_i(retire_pc),
    .retire_cls_i(retire_cls), .wait_cnt_i(wait_cnt), .hw_err_i(hw_err),
    .hw_err_code_i(err_code), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .issue_en_o(issue_a), .pc_load_o(pcl_a),
    .pc_load_addr_o(pcla_a), .status_o(st_a), .retire_cnt_o(cnt_a),
    .err_cap_code_o(ccode_a), .err_cap_pc_o(cpc_a), .err_irq_o(irq_a),
    .fatal_o(fat_a), .halt_irq_o(hirq_a)
  );

  runctl_unit #(.AUTO_RUN(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .retire_pc_i(retire_pc),
    .retire_cls_i(retire_cls), .wait_cnt_i(wait_cnt), .hw_err_i(hw_err),
    .hw_err_code_i(err_code), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .issue_en_o(issue_b), .pc_load_o(pcl_b),
    .pc_load_addr_o(pcla_b), .status_o(st_b), .retire_cnt_o(cnt_b),
    .err_cap_code_o(ccode_b), .err_cap_pc_o(cpc_b), .err_irq_o(irq_b),
    .fatal_o(fat_b), .halt_irq_o(hirq_b)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic ret(input logic [31:0] pc, input logic [1:0] cls, input logic [15:0] n);
    retire = 1'b1; retire_pc = pc; retire_cls = cls; wait_cnt = n;
    tick();
    retire = 1'b0;
  endtask

  task automatic err(input logic [7:0] code, input logic [31:0] pc);
    hw_err = 1'b1; err_code = code; retire_pc = pc;
    tick();
    hw_err = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status after reset", st_a, S_RUN);
    chk("R1 issue after reset", issue_a, 1);
    chk("R1 count after reset", cnt_a, 0);
    chk("R1 load addr is vector", pcla_a, 32'h100);
    chk("R2 variant B stopped", st_b, S_STOP);
    chk("R2 variant B no issue", issue_b, 0);
  endtask

  task automatic t_varb();
    do_reset();
    wr(3'd0, 32'h2);
    chk("R2 start ignored before arm", st_b, S_STOP);
    wr(3'd6, 32'h0);
    chk("R2 exec without base ignored", st_b, S_STOP);
    chk("R2 no load without base", pcl_b, 0);
    wr(3'd5, 32'h4000);
    wr(3'd6, 32'h0);
    chk("R2 exec runs", st_b, S_RUN);
    chk("R2 exec load pulse", pcl_b, 1);
    chk("R2 exec load addr", pcla_b, 32'h4000);
    tick();
    chk("R2 load pulse one cycle", pcl_b, 0);
  endtask

  task automatic t_bp();
    do_reset();
    ret(32'h10, 2'd0, 16'd0);
    chk("R4 reset breakpoint never hits", st_a, S_RUN);
    wr(3'd1, 32'h20);
    ret(32'h1C, 2'd0, 16'd0);
    chk("R3 non-matching pc runs", st_a, S_RUN);
    ret(32'h20, 2'd0, 16'd0);
    chk("R3 breakpoint stop", st_a, S_BRK);
    chk("R3 issue dropped", issue_a, 0);
    chk("R13 breakpoint instr counted", cnt_a, 3);
    wr(3'd0, 32'h2);
    chk("R6 start from breakpoint", st_a, S_RUN);
  endtask

  task automatic t_trap();
    do_reset();
    ret(32'h30, 2'd1, 16'd0);
    chk("R5 trap disabled is nop", st_a, S_RUN);
    wr(3'd2, 32'h1);
    ret(32'h34, 2'd1, 16'd0);
    chk("R5 trap enabled stops", st_a, S_BRK);
    wr(3'd0, 32'h1);
    chk("R6 stop from trap stop", st_a, S_STOP);
    wr(3'd0, 32'h2);
    chk("R6 start", st_a, S_RUN);
    wr(3'd0, 32'h3);
    chk("R6 stop wins over start", st_a, S_STOP);
  endtask

  task automatic t_wait();
    do_reset();
    ret(32'h40, 2'd2, 16'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R8 issue stalled", issue_a, 0);
      chk("R8 status running while stalled", st_a, S_RUN);
      tick();
    end
    chk("R8 issue back after n cycles", issue_a, 1);
    chk("R13 wait counts once", cnt_a, 1);
    ret(32'h44, 2'd2, 16'd0);
    chk("R7 wait 0 halts", st_a, S_HALT);
    chk("R7 halt irq", hirq_a, 1);
    tick();
    chk("R7 halt irq one cycle", hirq_a, 0);
    wr(3'd0, 32'h2);
    chk("R6 start from halt", st_a, S_RUN);
  endtask

  task automatic t_ovr();
    do_reset();
    wr(3'd3, 32'h500);
    chk("R9 override stops", st_a, S_STOP);
    chk("R9 load pulse", pcl_a, 1);
    chk("R9 load addr", pcla_a, 32'h500);
    tick(); tick();
    chk("R9 stays stopped", st_a, S_STOP);
    chk("R9 pulse ended", pcl_a, 0);
  endtask

  task automatic t_err();
    do_reset();
    err(8'h5A, 32'h44);
    chk("R10 irq pulse", irq_a, 1);
    chk("R10 running and locked", st_a, S_RUN | S_LOCK);
    chk("R10 capture code", ccode_a, 8'h5A);
    chk("R10 capture pc", cpc_a, 32'h44);
    tick();
    chk("R10 irq one cycle", irq_a, 0);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h2);
    chk("R12 start ignored when locked", st_a, S_STOP | S_LOCK);
    err(8'h33, 32'h48);
    chk("R11 fatal pulse", fat_a, 1);
    chk("R11 fatal state", st_a, S_FATAL | S_LOCK);
    chk("R11 capture kept", ccode_a, 8'h5A);
    tick();
    chk("R11 fatal one cycle", fat_a, 0);
    wr(3'd4, 32'h0);
    chk("R12 clear releases lock", st_a, S_FATAL);
    chk("R12 capture cleared", cpc_a, 0);
    wr(3'd0, 32'h2);
    chk("R12 start after clear", st_a, S_RUN);
  endtask

  task automatic t_same();
    do_reset();
    wr(3'd1, 32'h60);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h1;
    retire = 1'b1; retire_pc = 32'h60; retire_cls = 2'd0;
    tick();
    cfg_we = 1'b0; retire = 1'b0;
    chk("R14 stop beats breakpoint", st_a, S_STOP);
    wr(3'd0, 32'h2);
    err(8'h11, 32'h0);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h1;
    hw_err = 1'b1; err_code = 8'h22;
    tick();
    cfg_we = 1'b0; hw_err = 1'b0;
    chk("R14 fatal beats stop", st_a, S_FATAL | S_LOCK);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_varb();
    t_bp();
    t_trap();
    t_wait();
    t_ovr();
    t_err();
    t_same();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule